// File: doc/BRIEF.md
# Compact 16-bit Single-Cycle Load/Store Core

This block is a small single-cycle processor. Each clock edge it retires one 16-bit instruction fetched from its own instruction memory. The instruction is decoded and executed, and its result is written back in the same cycle. There are four general registers, 16 bits each, and the register fields are 2 bits wide. The opcode is 4 bits and immediates are 8 bits. The operation set covers add, subtract, and, or, nor, nand and a signed set-less-than, with an immediate-add variant. Memory access is by word load and word store, and control flow is by two conditional branches.

Both memories are filled through a preload port. A word write on that port always goes to the memory chosen by a select bit, whether or not the core is in reset. While the port is in use the core is frozen. For tracing, the core shows three values combinationally for the instruction about to retire: the current program counter, the value presented at the register-file write-data input, and the register write strobe.

Top module: `riscCore16`

## Requirements
- R1: While `rstN` is low, `pcOut` becomes 0 after a clock edge and `wbEn` is 0. After reset, all of registers 1 to 3 read as 0.
- R2: The R-format is op[15:12], rs[11:10], rt[9:8] and rd[7:6], with bits 5:0 ignored. The opcodes are 0000 add, 0001 sub (rs-rt), 0010 and, 0011 or, 0100 nor and 0101 nand. Each writes its 16-bit result to rd, with `wbEn`=1 and `wbData` equal to the result.
- R3: Register 0 always reads as 0. An instruction that targets register 0 still shows `wbEn`=1 and its value on `wbData`, but it leaves register 0 at 0.
- R4: addi (0111) uses the I-format op[15:12], rs[11:10], rt[9:8], imm[7:0]. It writes rs + sign-extended imm to rt.
- R5: The effective address is rs + sign-extended imm, taken as a byte address that must be even. It selects the data word at byte-address bits [9:1]. lw (1000) writes that word to rt. sw (1001) stores rt there and gives `wbEn`=0.
- R6: beq (1010) branches when rs equals rt, and bne (1011) branches when they differ. A taken branch loads PC+1 plus the sign-extended imm. A branch that is not taken loads PC+1. Both kinds give `wbEn`=0.
- R7: Every instruction that is not a taken branch advances the PC by exactly 1. `pcOut` shows the address of the instruction that retires at the next edge.
- R8: The undefined opcodes 1100 to 1111 write neither a register nor memory (`wbEn`=0) and advance the PC by 1.
- R9: With `loadEn`=1, the word on `loadData` is written at `loadAddr`: to instruction memory when `loadSel`=0 and to data memory when `loadSel`=1. `loadAddr` is a word index, so data word k is byte address 2k. While `loadEn` is high, the PC holds, `wbEn` is 0 and no instruction takes effect.
- R10: slt (0110) writes 1 to rd when rs is less than rt as signed two's-complement numbers, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| loadEn | input | 1 | Preload write strobe; freezes the core while high |
| loadSel | input | 1 | Preload target: 0 instruction memory, 1 data memory |
| loadAddr | input | 9 | Preload word index |
| loadData | input | 16 | Preload word |
| pcOut | output | 16 | Address of the current instruction |
| wbData | output | 16 | Value at the register-file write-data input |
| wbEn | output | 1 | Register write strobe of the current instruction |

## Verification
The condition hardest to reach from the ports is an ALU result that makes a difference only in the top bit or at the signed boundary, for example slt with 0x8000 against 0x7FFF. An 8-bit immediate cannot build such operands directly. The stimulus therefore preloads two 16-bit operands into data memory and loads them into registers. It then runs every register operation on every pair drawn from a set of corner values. Register-0 writes, stores at negative offsets and a freeze of the core in the middle of an instruction are reached with short dedicated programs, and the bench follows each of these programs instruction by instruction through `pcOut`.

// File: rtl/riscPkg.sv
package riscPkg;
  localparam int DATA_W    = 16;
  localparam int REG_COUNT = 4;
  localparam int REG_AW    = $clog2(REG_COUNT);
  localparam int IMM_W     = 8;
  // instruction field positions (decoded by control and datapath)
  localparam int OP_LSB = 12;
  localparam int RS_LSB = 10;
  localparam int RT_LSB = 8;
  localparam int RD_LSB = 6;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,  OP_SUB  = 4'd1,  OP_AND = 4'd2, OP_OR  = 4'd3,
    OP_NOR  = 4'd4,  OP_NAND = 4'd5,  OP_SLT = 4'd6, OP_ADDI = 4'd7,
    OP_LW   = 4'd8,  OP_SW   = 4'd9,  OP_BEQ = 4'd10, OP_BNE = 4'd11
  } opcode_e;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_NOR, ALU_NAND, ALU_SLT
  } aluOp_e;

  typedef struct packed {
    logic   regWrite;
    logic   dstIsRd;
    logic   srcIsImm;
    logic   memToReg;
    logic   memWrite;
    logic   brEq;
    logic   brNe;
    aluOp_e aluOp;
  } ctrlStrobes_t;
endpackage

// File: rtl/riscAlu.sv
module riscAlu
  import riscPkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  aluOp_e       op,
  output logic [W-1:0] y,
  output logic         zero
);
  logic [W-1:0] diff;
  logic         lessSigned;

  assign diff       = a - b;
  assign lessSigned = $signed(a) < $signed(b);
  assign zero       = (diff == '0);

  always_comb begin
    case (op)
      ALU_ADD:  y = a + b;
      ALU_SUB:  y = diff;
      ALU_AND:  y = a & b;
      ALU_OR:   y = a | b;
      ALU_NOR:  y = ~(a | b);
      ALU_NAND: y = ~(a & b);
      ALU_SLT:  y = {{(W-1){1'b0}}, lessSigned};
      default:  y = '0;
    endcase
  end
endmodule

// File: rtl/riscRegFile.sv
module riscRegFile
  import riscPkg::*;
#(
  parameter int W     = DATA_W,
  parameter int COUNT = REG_COUNT,
  localparam int AW   = $clog2(COUNT)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] aAddr,
  input  logic [AW-1:0] bAddr,
  input  logic [AW-1:0] wAddr,
  input  logic          we,
  input  logic [W-1:0]  wData,
  output logic [W-1:0]  aData,
  output logic [W-1:0]  bData
);
  logic [W-1:0] regQ [COUNT];

  // entry 0 is held at zero; the others load on a matching write
  always_ff @(posedge clk) begin
    regQ[0] <= '0;
    for (int i = 1; i < COUNT; i++) begin
      if (!rstN) regQ[i] <= '0;
      else if (we && wAddr == AW'(i)) regQ[i] <= wData;
    end
  end

  assign aData = regQ[aAddr];
  assign bData = regQ[bAddr];

  AST_R0_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rstN)
    (we && wAddr == '0) |=> (aAddr != '0 || aData == '0)); // R3
endmodule

// File: rtl/riscCtrl.sv
module riscCtrl
  import riscPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] instr,
  output ctrlStrobes_t      strobes
);
  opcode_e opc;
  assign opc = opcode_e'(instr[OP_LSB +: 4]);

  always_comb begin
    strobes = '0;
    strobes.aluOp = ALU_ADD;
    case (opc)
      OP_ADD:  begin strobes.regWrite = 1'b1; strobes.dstIsRd = 1'b1; strobes.aluOp = ALU_ADD;  end
      OP_SUB:  begin strobes.regWrite = 1'b1; strobes.dstIsRd = 1'b1; strobes.aluOp = ALU_SUB;  end
      OP_AND:  begin strobes.regWrite = 1'b1; strobes.dstIsRd = 1'b1; strobes.aluOp = ALU_AND;  end
      OP_OR:   begin strobes.regWrite = 1'b1; strobes.dstIsRd = 1'b1; strobes.aluOp = ALU_OR;   end
      OP_NOR:  begin strobes.regWrite = 1'b1; strobes.dstIsRd = 1'b1; strobes.aluOp = ALU_NOR;  end
      OP_NAND: begin strobes.regWrite = 1'b1; strobes.dstIsRd = 1'b1; strobes.aluOp = ALU_NAND; end
      OP_SLT:  begin strobes.regWrite = 1'b1; strobes.dstIsRd = 1'b1; strobes.aluOp = ALU_SLT;  end
      OP_ADDI: begin strobes.regWrite = 1'b1; strobes.srcIsImm = 1'b1; end
      OP_LW:   begin strobes.regWrite = 1'b1; strobes.srcIsImm = 1'b1; strobes.memToReg = 1'b1; end
      OP_SW:   begin strobes.memWrite = 1'b1; strobes.srcIsImm = 1'b1; end
      OP_BEQ:  begin strobes.brEq = 1'b1; strobes.aluOp = ALU_SUB; end
      OP_BNE:  begin strobes.brNe = 1'b1; strobes.aluOp = ALU_SUB; end
      default: strobes = '0;
    endcase
  end

  AST_UNDEF_IS_NOP: assert property (@(posedge clk) disable iff (!rstN)
    (instr[OP_LSB+3 -: 2] == 2'b11) |-> !(strobes.regWrite || strobes.memWrite || strobes.brEq || strobes.brNe)); // R8
endmodule

// File: rtl/riscDatapath.sv
module riscDatapath
  import riscPkg::*;
#(
  parameter int IMEM_WORDS = 512,
  parameter int DMEM_BYTES = 1024,
  localparam int IA_W      = $clog2(IMEM_WORDS),
  localparam int DA_W      = $clog2(DMEM_BYTES / 2),
  localparam int LOAD_AW   = (IA_W > DA_W) ? IA_W : DA_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               loadEn,
  input  logic               loadSel,
  input  logic [LOAD_AW-1:0] loadAddr,
  input  logic [DATA_W-1:0]  loadData,
  input  ctrlStrobes_t       strobes,
  output logic [DATA_W-1:0]  instr,
  output logic [DATA_W-1:0]  pcOut,
  output logic [DATA_W-1:0]  wbData,
  output logic               wbEn
);
  logic [DATA_W-1:0] imem [IMEM_WORDS];
  logic [DATA_W-1:0] dmem [DMEM_BYTES / 2];
  logic [DATA_W-1:0] pcQ, pcPlus1, pcNext, immExt;
  logic [DATA_W-1:0] rsData, rtData, aluB, aluY, memRd;
  logic [REG_AW-1:0] dstAddr;
  logic [DA_W-1:0]   memIdx;
  logic              run, aluZero, taken;

  assign run = rstN && !loadEn;

  // instruction memory: preload writes, combinational fetch
  always_ff @(posedge clk) begin
    if (loadEn && !loadSel) imem[loadAddr[IA_W-1:0]] <= loadData;
  end
  assign instr  = imem[pcQ[IA_W-1:0]];
  assign immExt = {{(DATA_W-IMM_W){instr[IMM_W-1]}}, instr[IMM_W-1:0]};

  riscRegFile #(.W(DATA_W), .COUNT(REG_COUNT)) i_regs (
    .clk(clk), .rstN(rstN),
    .aAddr(instr[RS_LSB +: REG_AW]), .bAddr(instr[RT_LSB +: REG_AW]),
    .wAddr(dstAddr), .we(wbEn), .wData(wbData),
    .aData(rsData), .bData(rtData)
  );

  assign aluB = strobes.srcIsImm ? immExt : rtData;

  riscAlu #(.W(DATA_W)) i_alu (
    .a(rsData), .b(aluB), .op(strobes.aluOp), .y(aluY), .zero(aluZero)
  );

  // data memory: byte address, word granule
  assign memIdx = aluY[DA_W:1];
  always_ff @(posedge clk) begin
    if (loadEn && loadSel)            dmem[loadAddr[DA_W-1:0]] <= loadData;
    else if (run && strobes.memWrite) dmem[memIdx] <= rtData;
  end
  assign memRd = dmem[memIdx];

  assign dstAddr = strobes.dstIsRd ? instr[RD_LSB +: REG_AW] : instr[RT_LSB +: REG_AW];
  assign wbData  = strobes.memToReg ? memRd : aluY;
  assign wbEn    = strobes.regWrite && run;

  // next PC
  assign taken   = (strobes.brEq && aluZero) || (strobes.brNe && !aluZero);
  assign pcPlus1 = pcQ + DATA_W'(1);
  assign pcNext  = taken ? (pcPlus1 + immExt) : pcPlus1;

  always_ff @(posedge clk) begin
    if (!rstN)       pcQ <= '0;
    else if (!loadEn) pcQ <= pcNext;
  end
  assign pcOut = pcQ;

  AST_PC_STEP_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (!loadEn && !taken) |=> (pcQ == $past(pcQ) + DATA_W'(1))); // R7
  AST_BRANCH_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    (!loadEn && taken) |=> (pcQ == $past(pcQ) + DATA_W'(1) + $past(immExt))); // R6
  AST_LOAD_FREEZES_PC: assert property (@(posedge clk) disable iff (!rstN)
    loadEn |=> $stable(pcQ)); // R9
  AST_STORE_NO_WRITEBACK: assert property (@(posedge clk) disable iff (!rstN)
    strobes.memWrite |-> !wbEn); // R5
endmodule

// File: rtl/riscCore16.sv
module riscCore16
  import riscPkg::*;
#(
  parameter int IMEM_WORDS = 512,
  parameter int DMEM_BYTES = 1024,
  localparam int LOAD_AW   = ($clog2(IMEM_WORDS) > $clog2(DMEM_BYTES / 2)) ?
                             $clog2(IMEM_WORDS) : $clog2(DMEM_BYTES / 2)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               loadEn,
  input  logic               loadSel,
  input  logic [LOAD_AW-1:0] loadAddr,
  input  logic [DATA_W-1:0]  loadData,
  output logic [DATA_W-1:0]  pcOut,
  output logic [DATA_W-1:0]  wbData,
  output logic               wbEn
);
  ctrlStrobes_t      strobes;
  logic [DATA_W-1:0] instr;

  riscCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .instr(instr), .strobes(strobes)
  );

  riscDatapath #(.IMEM_WORDS(IMEM_WORDS), .DMEM_BYTES(DMEM_BYTES)) i_dp (
    .clk(clk), .rstN(rstN),
    .loadEn(loadEn), .loadSel(loadSel), .loadAddr(loadAddr), .loadData(loadData),
    .strobes(strobes), .instr(instr),
    .pcOut(pcOut), .wbData(wbData), .wbEn(wbEn)
  );
endmodule

// File: tb/test_riscCore16.sv
`timescale 1ns/1ps
module test_riscCore16;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        loadEn = 1'b0;
  logic        loadSel = 1'b0;
  logic [8:0]  loadAddr = '0;
  logic [15:0] loadData = '0;
  logic [15:0] pcOut, wbData;
  logic        wbEn;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [15:0] prog [0:299];

  riscCore16 i_riscCore16 (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .loadSel(loadSel),
    .loadAddr(loadAddr), .loadData(loadData),
    .pcOut(pcOut), .wbData(wbData), .wbEn(wbEn)
  );

  always #2.5 clk = ~clk;

  function automatic logic [15:0] rFmt(int op, int rs, int rt, int rd);
    return {4'(op), 2'(rs), 2'(rt), 2'(rd), 6'b0};
  endfunction
  function automatic logic [15:0] iFmt(int op, int rs, int rt, int imm);
    return {4'(op), 2'(rs), 2'(rt), 8'(imm)};
  endfunction
  function automatic logic [15:0] aluRef(int op, logic [15:0] a, logic [15:0] b);
    case (op)
      0: return a + b;
      1: return a - b;
      2: return a & b;
      3: return a | b;
      4: return ~(a | b);
      5: return ~(a & b);
      default: return ($signed(a) < $signed(b)) ? 16'd1 : 16'd0;
    endcase
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic expectStep(string tag, int expPc, bit expEn, logic [15:0] expData);
    check({tag, " pc R7"}, pcOut, 16'(expPc));
    check({tag, " wbEn"}, {15'b0, wbEn}, {15'b0, expEn});
    if (expEn) check({tag, " wbData"}, wbData, expData);
  endtask

  task automatic loadWord(bit sel, int addr, logic [15:0] d);
    loadEn = 1'b1; loadSel = sel; loadAddr = 9'(addr); loadData = d;
    @(negedge clk);
    loadEn = 1'b0;
  endtask

  task automatic loadProg(int n);
    for (int i = 0; i < n; i++) loadWord(1'b0, i, prog[i]);
  endtask

  task automatic startRun();
    rstN = 1'b0;
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    #1;
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL R7 watchdog actual=running expected=finished");
    finishRun();
  end

  logic [15:0] vals [8] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000,
                            16'hFFFF, 16'h1234, 16'hA5A5, 16'h00FF};

  initial begin
    @(negedge clk);
    // ALU program: two loads, every R-op, register-0 cases, self loop
    prog[0] = iFmt(8, 0, 1, 0);
    prog[1] = iFmt(8, 0, 2, 2);
    for (int k = 0; k < 7; k++) prog[2+k] = rFmt(k, 1, 2, 3);
    prog[9]  = rFmt(0, 1, 2, 0);
    prog[10] = rFmt(0, 0, 0, 3);
    prog[11] = rFmt(3, 0, 1, 3);
    prog[12] = iFmt(10, 0, 0, -1);
    loadProg(13);
    // R1: reset state
    check("R1 reset pc", pcOut, 16'h0000);
    check("R1 reset wbEn", {15'b0, wbEn}, 16'h0000);

    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        logic [15:0] a, b;
        a = vals[i]; b = vals[j];
        rstN = 1'b0;
        loadWord(1'b1, 0, a);
        loadWord(1'b1, 1, b);
        startRun();
        expectStep("R5 lw a", 0, 1'b1, a); step();
        expectStep("R5 lw b", 1, 1'b1, b); step();
        for (int k = 0; k < 7; k++) begin
          expectStep((k == 6) ? "R10 slt" : "R2 alu", 2 + k, 1'b1, aluRef(k, a, b));
          step();
        end
        expectStep("R3 write r0", 9, 1'b1, a + b); step();
        expectStep("R3 r0 reads zero", 10, 1'b1, 16'h0000); step();
        expectStep("R3 or with r0", 11, 1'b1, a); step();
        expectStep("R6 self loop", 12, 1'b0, 16'h0000); step();
        expectStep("R6 self loop again", 12, 1'b0, 16'h0000);
      end
    end

    // memory program: also shows registers cleared by reset
    rstN = 1'b0;
    prog[0] = rFmt(3, 1, 2, 3);
    prog[1] = iFmt(8, 0, 1, 0);
    prog[2] = iFmt(7, 0, 2, 10);
    prog[3] = iFmt(9, 2, 1, -2);
    prog[4] = iFmt(8, 0, 3, 8);
    prog[5] = iFmt(7, 0, 2, 100);
    prog[6] = iFmt(9, 2, 2, 20);
    prog[7] = iFmt(8, 0, 1, 120);
    prog[8] = iFmt(8, 0, 3, 10);
    prog[9] = iFmt(10, 0, 0, -1);
    loadProg(10);
    loadWord(1'b1, 0, 16'hBEEF);
    loadWord(1'b1, 4, 16'h1111);
    loadWord(1'b1, 5, 16'h5A5A);
    loadWord(1'b1, 60, 16'h2222);
    startRun();
    expectStep("R1 regs cleared", 0, 1'b1, 16'h0000); step();
    expectStep("R5 lw word0", 1, 1'b1, 16'hBEEF); step();
    expectStep("R4 addi 10", 2, 1'b1, 16'd10); step();
    expectStep("R5 sw neg offset", 3, 1'b0, 16'h0000); step();
    expectStep("R5 lw stored", 4, 1'b1, 16'hBEEF); step();
    expectStep("R4 addi 100", 5, 1'b1, 16'd100); step();
    expectStep("R5 sw pos offset", 6, 1'b0, 16'h0000); step();
    expectStep("R5 lw byte120", 7, 1'b1, 16'd100); step();
    expectStep("R9 lw preload byte10", 8, 1'b1, 16'h5A5A); step();
    expectStep("R6 mem loop", 9, 1'b0, 16'h0000);

    // addi sweep over every 8-bit immediate
    rstN = 1'b0;
    prog[0] = iFmt(8, 0, 1, 0);
    for (int k = 0; k < 256; k++) prog[1+k] = iFmt(7, 1, 2, k);
    prog[257] = iFmt(10, 0, 0, -1);
    loadProg(258);
    loadWord(1'b1, 0, 16'h8010);
    startRun();
    expectStep("R5 lw base", 0, 1'b1, 16'h8010); step();
    for (int k = 0; k < 256; k++) begin
      expectStep("R4 addi sweep", 1 + k, 1'b1, 16'h8010 + {{8{k[7]}}, 8'(k)});
      step();
    end
    expectStep("R6 sweep loop", 257, 1'b0, 16'h0000);

    // branches, undefined opcodes and a freeze through the preload port
    rstN = 1'b0;
    prog[0]  = iFmt(7, 0, 1, 5);
    prog[1]  = iFmt(7, 0, 2, 5);
    prog[2]  = iFmt(10, 1, 2, 2);
    prog[3]  = iFmt(7, 0, 3, 1);
    prog[4]  = iFmt(7, 0, 3, 2);
    prog[5]  = iFmt(11, 1, 2, 3);
    prog[6]  = iFmt(7, 0, 2, 6);
    prog[7]  = iFmt(11, 1, 2, 1);
    prog[8]  = iFmt(7, 0, 3, 7);
    prog[9]  = iFmt(10, 1, 2, -10);
    prog[10] = 16'hC123;
    prog[11] = 16'hF000;
    prog[12] = iFmt(10, 0, 0, -1);
    loadProg(13);
    startRun();
    expectStep("R4 addi r1", 0, 1'b1, 16'd5); step();
    expectStep("R4 addi r2", 1, 1'b1, 16'd5);
    // R9: freeze while the preload port writes data memory
    loadEn = 1'b1; loadSel = 1'b1; loadAddr = 9'd200; loadData = 16'h7777;
    #1;
    expectStep("R9 frozen start", 1, 1'b0, 16'h0000);
    repeat (3) step();
    expectStep("R9 frozen hold", 1, 1'b0, 16'h0000);
    loadEn = 1'b0;
    #1;
    expectStep("R9 resume", 1, 1'b1, 16'd5); step();
    expectStep("R6 beq taken", 2, 1'b0, 16'h0000); step();
    expectStep("R6 bne not taken", 5, 1'b0, 16'h0000); step();
    expectStep("R4 addi r2=6", 6, 1'b1, 16'd6); step();
    expectStep("R6 bne taken", 7, 1'b0, 16'h0000); step();
    expectStep("R6 beq not taken", 9, 1'b0, 16'h0000); step();
    expectStep("R8 undefined C", 10, 1'b0, 16'h0000); step();
    expectStep("R8 undefined F", 11, 1'b0, 16'h0000); step();
    expectStep("R6 backward taken", 12, 1'b0, 16'h0000); step();
    expectStep("R6 backward again", 12, 1'b0, 16'h0000);
    // R1: reset in the middle of a run
    rstN = 1'b0;
    @(negedge clk); #1;
    check("R1 mid reset pc", pcOut, 16'h0000);
    check("R1 mid reset wbEn", {15'b0, wbEn}, 16'h0000);

    finishRun();
  end
endmodule